// File: doc/BRIEF.md
# In-Order Request Channel with Read Forwarding

This block sits between a requester and a memory-side manager and holds memory request messages in the order they arrived. Each entry carries an operation (read, write or compare-and-swap), an address, a data word and an event tag. Entries leave toward the manager strictly oldest first over a valid/ready port.

While a read waits in the queue, it can be answered from an older queued write to the same address. This is allowed only when no entry between the two names that address and none of them is a compare-and-swap. In that case the read is taken out of the queue and never reaches the manager. A response carrying the write's data, the read's tag and the read opcode appears on a separate response port. The write stays queued and drains normally. When an enqueue, a dequeue and a forward happen in the same cycle, the survivors are compacted and keep their relative order.

Top module: `req_chan_fwd`

## Requirements
- R1: While `rst` is high at a rising edge, the queue empties. After reset `out_valid` and `rsp_valid` are low and `in_ready` is high.
- R2: `in_ready` is high exactly when fewer than `DEPTH` entries are held. An `in_valid` offered while `in_ready` is low is dropped and changes nothing that is later presented.
- R3: Opcodes are encoded as 0 = read, 1 = write and 2 = compare-and-swap. The output port presents the oldest held entry. A transfer happens on `out_valid && out_ready`, and entries leave in arrival order.
- R4: While `out_valid` is high and `out_ready` is low, the presented entry stays unchanged in the next cycle.
- R5: A held read is eligible when, scanning the older entries from youngest to oldest, the first one that names the read's address or is a compare-and-swap is a write to that address. An eligible read drives `rsp_valid` with `rsp_op` = 0, the read's tag and that write's data.
- R6: A read is not forwarded when a compare-and-swap at any address, or a read or compare-and-swap to the same address, sits between it and the closest older write to its address.
- R7: When several older writes name the read's address, the youngest of them supplies `rsp_data`.
- R8: A forwarded read is removed at the clock edge that ends its response cycle and never appears on the output port. The write that supplied the data stays in the queue.
- R9: At most one forward happens per cycle, and the oldest eligible read is chosen. A read becomes eligible combinationally from the held state, so it is forwarded in the first cycle in which it is held.
- R10: An enqueue, a dequeue and a forward in the same cycle together change the occupancy by +1-1-1. The remaining entries keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New request offered |
| in_ready | output | 1 | A slot is free |
| in_op | input | 2 | Request opcode (0 read, 1 write, 2 compare-and-swap) |
| in_addr | input | ADDR_W | Request address |
| in_data | input | DATA_W | Request data |
| in_tag | input | TAG_W | Request event tag |
| out_valid | output | 1 | Oldest entry presented |
| out_ready | input | 1 | Manager accepts the presented entry |
| out_op | output | 2 | Opcode of the presented entry |
| out_addr | output | ADDR_W | Address of the presented entry |
| out_data | output | DATA_W | Data of the presented entry |
| out_tag | output | TAG_W | Tag of the presented entry |
| rsp_valid | output | 1 | A read is being answered by forwarding this cycle |
| rsp_op | output | 2 | Opcode of the forwarded read (always 0) |
| rsp_data | output | DATA_W | Data taken from the supplying write |
| rsp_tag | output | TAG_W | Tag of the forwarded read |

## Verification
The bench builds the channel with `DEPTH` = 4 so that the full-queue refusal and same-cycle compaction at a full or nearly full queue are reached within a few cycles. Addresses are drawn from only four values, which makes same-address collisions, intervening compare-and-swaps and multiple older writes to one address common rather than rare. Directed sequences cover the blocking, youngest-write and combined enqueue/dequeue/forward cases before a long randomized phase.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;
    parameter int TAG_W  = 8;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CAS   = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } entry_t;

    // An older entry stands between a read and its source when it
    // touches the read's address or is an atomic at any address.
    function automatic logic fences(entry_t older, logic [ADDR_W-1:0] rd_addr);
        return (older.addr == rd_addr) || (older.op == OP_CAS);
    endfunction

    function automatic logic supplies(entry_t older, logic [ADDR_W-1:0] rd_addr);
        return (older.op == OP_WRITE) && (older.addr == rd_addr);
    endfunction

endpackage

// File: rtl/rcf_fwd_pick.sv
module rcf_fwd_pick
    import rcf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  entry_t        ents [DEPTH],
    input  logic [CW-1:0] count,
    output logic          hit,
    output logic [IW-1:0] rd_idx,
    output logic [IW-1:0] wr_idx
);

    always_comb begin
        hit    = 1'b0;
        rd_idx = '0;
        wr_idx = '0;
        // Slot 0 has no older entry, so the scan of reads starts at 1.
        for (int j = 1; j < DEPTH; j++) begin
            logic fenced;
            logic fence_is_src;
            int   fence_at;
            fenced       = 1'b0;
            fence_is_src = 1'b0;
            fence_at     = 0;
            // Oldest to youngest: the last fence seen is the nearest one.
            for (int i = 0; i < j; i++) begin
                if (i < int'(count) && fences(ents[i], ents[j].addr)) begin
                    fenced       = 1'b1;
                    fence_is_src = supplies(ents[i], ents[j].addr);
                    fence_at     = i;
                end
            end
            if (!hit && j < int'(count) && ents[j].op == OP_READ
                    && fenced && fence_is_src) begin
                hit    = 1'b1;
                rd_idx = IW'(j);
                wr_idx = IW'(fence_at);
            end
        end
    end

    // R5: a chosen pair is an older write and a younger read to one address
    assert_fwd_pair_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> (wr_idx < rd_idx) && (ents[wr_idx].op == OP_WRITE)
                && (ents[rd_idx].op == OP_READ)
                && (ents[wr_idx].addr == ents[rd_idx].addr)
                && (int'(rd_idx) < int'(count)));

    // R8: the head is never removed by forwarding, only by a transfer
    assert_fwd_not_head_R8: assert property (@(posedge clk) disable iff (rst)
        hit |-> (rd_idx != '0));

endmodule

// File: rtl/rcf_compact.sv
module rcf_compact
    import rcf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  entry_t        ents [DEPTH],
    input  logic [CW-1:0] count,
    input  logic          deq,
    input  logic          fwd,
    input  logic [IW-1:0] fwd_idx,
    input  logic          enq,
    input  entry_t        enq_ent,
    output entry_t        nxt [DEPTH],
    output logic [CW-1:0] nxt_count
);

    always_comb begin
        int fill;
        fill = 0;
        for (int k = 0; k < DEPTH; k++) nxt[k] = ents[k];
        // Survivors slide down in arrival order; the new entry lands after them.
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(count) && !(deq && i == 0)
                    && !(fwd && int'(fwd_idx) == i)) begin
                nxt[fill] = ents[i];
                fill      = fill + 1;
            end
        end
        if (enq && fill < DEPTH) begin
            nxt[fill] = enq_ent;
            fill      = fill + 1;
        end
        nxt_count = CW'(fill);
    end

endmodule

// File: rtl/req_chan_fwd.sv
module req_chan_fwd
    import rcf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_op,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  out_tag,
    output logic              rsp_valid,
    output logic [1:0]        rsp_op,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag
);

    entry_t        ents_q [DEPTH];
    entry_t        ents_n [DEPTH];
    logic [CW-1:0] count_q;
    logic [CW-1:0] count_n;
    logic          fwd_hit;
    logic [IW-1:0] fwd_rd;
    logic [IW-1:0] fwd_wr;
    logic          enq_fire;
    logic          deq_fire;
    logic          run_q;
    entry_t        in_ent;

    assign in_ready  = (count_q != CW'(DEPTH));
    assign out_valid = (count_q != '0);
    assign enq_fire  = in_valid && in_ready;
    assign deq_fire  = out_valid && out_ready;

    always_comb begin
        in_ent.op   = op_e'(in_op);
        in_ent.addr = in_addr;
        in_ent.data = in_data;
        in_ent.tag  = in_tag;
    end

    rcf_fwd_pick #(.DEPTH(DEPTH)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .ents   (ents_q),
        .count  (count_q),
        .hit    (fwd_hit),
        .rd_idx (fwd_rd),
        .wr_idx (fwd_wr)
    );

    rcf_compact #(.DEPTH(DEPTH)) u_compact (
        .ents      (ents_q),
        .count     (count_q),
        .deq       (deq_fire),
        .fwd       (fwd_hit),
        .fwd_idx   (fwd_rd),
        .enq       (enq_fire),
        .enq_ent   (in_ent),
        .nxt       (ents_n),
        .nxt_count (count_n)
    );

    assign out_op    = ents_q[0].op;
    assign out_addr  = ents_q[0].addr;
    assign out_data  = ents_q[0].data;
    assign out_tag   = ents_q[0].tag;

    assign rsp_valid = fwd_hit;
    assign rsp_op    = ents_q[fwd_rd].op;
    assign rsp_data  = ents_q[fwd_wr].data;
    assign rsp_tag   = ents_q[fwd_rd].tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else begin
            count_q <= count_n;
            run_q   <= 1'b1;
        end
        ents_q <= ents_n;
    end

    // R2: occupancy never exceeds the configured depth
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        int'(count_q) <= DEPTH);

    // R10: occupancy moves by exactly enqueue minus dequeue minus forward
    assert_count_balance_R10: assert property (@(posedge clk) disable iff (rst || !run_q)
        int'(count_q) == int'($past(count_q)) + int'($past(enq_fire))
                         - int'($past(deq_fire)) - int'($past(fwd_hit)));

    // R4: a stalled head stays put
    assert_head_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_addr)
                                       && $stable(out_data) && $stable(out_tag)));

    // R5: responses only ever answer reads
    assert_rsp_is_read_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_op == OP_READ));

endmodule

// File: tb/req_chan_fwd_test.sv
`timescale 1ns/1ps
module req_chan_fwd_test;
    import rcf_pkg::*;

    localparam int DEPTH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [1:0]        in_op = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic [TAG_W-1:0]  in_tag = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [1:0]        out_op;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;
    logic [TAG_W-1:0]  out_tag;
    logic              rsp_valid;
    logic [1:0]        rsp_op;
    logic [DATA_W-1:0] rsp_data;
    logic [TAG_W-1:0]  rsp_tag;

    always #2 clk = ~clk;

    req_chan_fwd #(.DEPTH(DEPTH)) uut (.*);

    typedef struct {
        int op;
        int addr;
        int data;
        int tag;
    } mrec_t;

    mrec_t q[$];
    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    done   = 0;

    task automatic check(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", phase, what, act, exp);
        end
    endtask

    // Returns the index of the oldest forwardable read, -1 if none.
    function automatic int model_pick(output int src);
        src = -1;
        for (int j = 0; j < q.size(); j++) begin
            if (q[j].op == 0) begin
                for (int i = j - 1; i >= 0; i--) begin
                    if (q[i].addr == q[j].addr || q[i].op == 2) begin
                        if (q[i].op == 1 && q[i].addr == q[j].addr) begin
                            src = i;
                            return j;
                        end
                        break;
                    end
                end
            end
        end
        return -1;
    endfunction

    task automatic compare();
        int src;
        int rd;
        rd = model_pick(src);
        check("in_ready", in_ready, q.size() < DEPTH);
        check("out_valid", out_valid, q.size() > 0);
        if (q.size() > 0) begin
            check("out_op", out_op, q[0].op);
            check("out_addr", out_addr, q[0].addr);
            check("out_data", out_data, q[0].data);
            check("out_tag", out_tag, q[0].tag);
        end
        check("rsp_valid", rsp_valid, rd >= 0);
        if (rd >= 0) begin
            check("rsp_op", rsp_op, 0);
            check("rsp_data", rsp_data, q[src].data);
            check("rsp_tag", rsp_tag, q[rd].tag);
        end
    endtask

    task automatic tick(bit v, int op, int a, int d, int t, bit ordy);
        int src;
        int rd;
        bit deq;
        bit enq;
        @(negedge clk);
        compare();
        in_valid  = v;
        in_op     = 2'(op);
        in_addr   = ADDR_W'(a);
        in_data   = DATA_W'(d);
        in_tag    = TAG_W'(t);
        out_ready = ordy;
        @(posedge clk);
        if (rst) begin
            q.delete();
        end else begin
            rd  = model_pick(src);
            deq = ordy && q.size() > 0;
            enq = v && q.size() < DEPTH;
            if (rd >= 0) q.delete(rd);
            if (deq) void'(q.pop_front());
            if (enq) q.push_back('{op: op, addr: a, data: d, tag: t});
        end
    endtask

    task automatic idle(int n, bit ordy);
        for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0, ordy);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        phase = "R1";
        rst = 1'b1;
        idle(3, 0);
        @(negedge clk);
        rst = 1'b0;
        idle(2, 0);

        // R2 R4: fill past depth with a stalled manager, extra offer dropped
        phase = "R2 R4";
        for (int k = 0; k < DEPTH + 2; k++) tick(1, 1, 10 + k, 100 + k, k, 0);
        idle(2, 0);
        // R3: drain in order
        phase = "R3";
        idle(DEPTH + 2, 1);

        // R5 R8: simple forward, read never drains
        phase = "R5 R8";
        tick(1, 1, 3, 'hAA, 1, 0);
        tick(1, 0, 3, 0, 2, 0);
        idle(2, 0);
        idle(3, 1);

        // R6: compare-and-swap at another address blocks, same-addr read blocks
        phase = "R6";
        tick(1, 1, 3, 'h11, 3, 0);
        tick(1, 2, 1, 'h22, 4, 0);
        tick(1, 0, 3, 0, 5, 0);
        idle(2, 0);
        idle(4, 1);
        tick(1, 1, 2, 'h33, 6, 0);
        tick(1, 0, 2, 0, 7, 0);
        tick(1, 2, 2, 'h44, 8, 0);
        tick(1, 0, 2, 0, 9, 0);
        idle(2, 0);
        idle(4, 1);

        // R7: youngest of several writes supplies data
        phase = "R7";
        tick(1, 1, 0, 'h55, 10, 0);
        tick(1, 1, 0, 'h66, 11, 0);
        tick(1, 0, 0, 0, 12, 0);
        idle(2, 0);
        idle(3, 1);

        // R9: back-to-back reads forwarded one per cycle
        phase = "R9";
        tick(1, 1, 1, 'h77, 13, 0);
        tick(1, 0, 1, 0, 14, 0);
        tick(1, 0, 1, 0, 15, 0);
        tick(1, 0, 1, 0, 16, 0);
        idle(2, 0);
        idle(2, 1);

        // R10: enqueue, dequeue and forward together
        phase = "R10";
        tick(1, 1, 2, 'h88, 17, 0);
        tick(1, 1, 3, 'h99, 18, 0);
        tick(1, 0, 3, 0, 19, 1);
        tick(1, 0, 2, 0, 20, 1);
        tick(1, 1, 0, 'hBB, 21, 1);
        idle(4, 1);

        // R3: randomized traffic over a small address set
        phase = "R3";
        for (int k = 0; k < 3000; k++) begin
            tick(($urandom % 10) < 7, $urandom % 3, $urandom % 4,
                 $urandom % 65536, k % 256, ($urandom % 2) == 1);
        end
        idle(DEPTH + 2, 1);

        done = 1;
        summary();
        $finish;
    end

endmodule